// File: doc/BRIEF.md
# Per-Source Configured Interrupt Controller

This block is a primary interrupt controller that collects 64 level-sensitive interrupt lines and raises a single IRQ line towards the processor. Each source has a 32-bit configuration word of its own. The low 7 bits of that word form a routing field. A source takes part in arbitration only while this field holds the exact enable code of the chosen register-map variant. The upper bits are plain storage, so software can update the field by read-modify-write.

The processor services an interrupt by reading one selection word. That word carries a pending flag and the number of the lowest-numbered source that is enabled and active. Software then masks that source by clearing its field, services the device, and unmasks the source by writing the enable code back. A parameter chooses one of two register-map variants. The variants differ in the enable code and in the offset of the selection word. Register access uses a plain valid/write/address/data port, and read data returns one cycle after the request.

Top module: `srcfg_intc`

## Requirements
- R1: After reset every configuration word reads 0, `irq_o` is low and the selection word reads 0.
- R2: A write to byte offset 4*n (n from 0 to 63) stores all 32 data bits into the configuration word of source n. A read of that offset returns all 32 bits unchanged, including bits 31:7.
- R3: Source n is enabled only when bits 6:0 of its word equal the enable code: 0x51 in map A (`MAP`=0) and 0x20 in map B (`MAP`=1). Bits 31:7 do not affect this. Any other field value, including 0x00 and the other variant's code, keeps the source out of the selection.
- R4: The selection word is at offset 0x10C in map A and at 0x104 in map B. Bit 6 is the pending flag, bits 5:0 hold the source number, and bits 31:7 read 0. In each map the other variant's offset is unmapped.
- R5: When several enabled sources are active, the selection reports the lowest-numbered one.
- R6: The selection and `irq_o` are registered. One cycle after an input or configuration change they reflect the new level-sensitive state, and they clear once no enabled source is active.
- R7: `irq_o` always equals the pending flag of the selection word.
- R8: Writes to the selection word, to unmapped offsets and to offsets that are not multiples of 4 change nothing. Reads of such offsets return 0.
- R9: Read data appears on `rsp_rdata_o` on the clock edge that ends the read request and holds until the next read.
- R10: Clearing the field of the reported source moves the selection to the next lowest enabled active source. Restoring the enable code makes that source the selection again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Register access request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 12 | Byte offset |
| req_wdata_i | input | 32 | Write data |
| rsp_rdata_o | output | 32 | Registered read data |
| irq_src_i | input | 64 | Level interrupt inputs, bit n = source n |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The bench first drives a single source with upper bits set in its word. This shows whether the field comparison ignores the storage bits. It then drives several sources at once with the low, middle and top source numbers all active, which shows whether the arbitration picks the lowest number rather than the highest or the last one written. Wrong field values are tried on an active line: 0x00, a near-miss code and the other map's code. Together they separate an exact-match decode from a non-zero or partial-bit test. A second instance built for map B shares the same stimulus, so one run shows that each map responds only at its own selection offset and to its own code. A mask-service-unmask sequence and a final release of all lines check that the selection follows levels rather than latched events.

// File: rtl/srcfg_intc_pkg.sv
package srcfg_intc_pkg;
  localparam int unsigned NUM_SRC = 64;
  localparam int unsigned ID_W    = $clog2(NUM_SRC);
  localparam int unsigned FIELD_W = 7;
  localparam int unsigned DATA_W  = 32;

  typedef enum logic {MAP_A = 1'b0, MAP_B = 1'b1} map_e;

  typedef struct packed {
    logic            vld;
    logic [ID_W-1:0] id;
  } sel_t;

  function automatic logic [FIELD_W-1:0] en_code(map_e m);
    return (m == MAP_B) ? FIELD_W'(7'h20) : FIELD_W'(7'h51);
  endfunction

  function automatic int unsigned sel_offset(map_e m);
    return (m == MAP_B) ? 32'h104 : 32'h10C;
  endfunction
endpackage

// File: rtl/srcfg_intc_cfg_bank.sv
module srcfg_intc_cfg_bank #(
  parameter int unsigned NUM    = 64,
  parameter int unsigned DW     = 32,
  parameter int unsigned FW     = 7,
  parameter int unsigned WORD_W = 10,
  parameter logic [FW-1:0] CODE = 7'h51
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] widx_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     cfg_o [NUM],
  output logic [NUM-1:0]    en_o
);
  for (genvar n = 0; n < NUM; n++) begin : g_src
    logic [DW-1:0] cfg_q;
    logic          hit;

    assign hit = wr_i && (widx_i == WORD_W'(n));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  cfg_q <= '0;
      else if (hit) cfg_q <= wdata_i;
    end

    // exact match of the routing field only
    assign en_o[n]  = (cfg_q[FW-1:0] == CODE);
    assign cfg_o[n] = cfg_q;
  end
endmodule

// File: rtl/srcfg_intc_prio.sv
module srcfg_intc_prio #(
  parameter int unsigned NUM  = 64,
  parameter int unsigned ID_W = 6
) (
  input  logic [NUM-1:0]  pend_i,
  output logic            vld_o,
  output logic [ID_W-1:0] id_o
);
  // scan from the top so the lowest set bit wins
  always_comb begin
    vld_o = 1'b0;
    id_o  = '0;
    for (int i = NUM - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        vld_o = 1'b1;
        id_o  = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/srcfg_intc_sel.sv
module srcfg_intc_sel
  import srcfg_intc_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            vld_i,
  input  logic [ID_W-1:0] id_i,
  output sel_t            sel_o
);
  sel_t sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= '0;
    else         sel_q <= '{vld: vld_i, id: (vld_i ? id_i : '0)};
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/srcfg_intc.sv
module srcfg_intc
  import srcfg_intc_pkg::*;
#(
  parameter map_e        MAP    = MAP_A,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic [DATA_W-1:0] rsp_rdata_o,
  input  logic [NUM_SRC-1:0] irq_src_i,
  output logic              irq_o
);
  localparam int unsigned   WORD_W  = ADDR_W - 2;
  localparam logic [WORD_W-1:0] SEL_IDX = WORD_W'(sel_offset(MAP) / 4);
  localparam logic [WORD_W-1:0] CFG_END = WORD_W'(NUM_SRC);
  localparam logic [FIELD_W-1:0] CODE   = en_code(MAP);

  logic [WORD_W-1:0]  word_idx;
  logic               aligned, hit_cfg, hit_sel;
  logic [DATA_W-1:0]  cfg_q [NUM_SRC];
  logic [NUM_SRC-1:0] en_vec, pend_vec;
  logic               nxt_vld;
  logic [ID_W-1:0]    nxt_id;
  sel_t               sel_q;
  logic [DATA_W-1:0]  rd_val, rsp_q;

  assign word_idx = req_addr_i[ADDR_W-1:2];
  assign aligned  = (req_addr_i[1:0] == 2'b00);
  assign hit_cfg  = aligned && (word_idx < CFG_END);
  assign hit_sel  = aligned && (word_idx == SEL_IDX);

  srcfg_intc_cfg_bank #(
    .NUM(NUM_SRC), .DW(DATA_W), .FW(FIELD_W), .WORD_W(WORD_W), .CODE(CODE)
  ) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (req_valid_i && req_write_i && hit_cfg),
    .widx_i  (word_idx),
    .wdata_i (req_wdata_i),
    .cfg_o   (cfg_q),
    .en_o    (en_vec)
  );

  assign pend_vec = irq_src_i & en_vec;

  srcfg_intc_prio #(.NUM(NUM_SRC), .ID_W(ID_W)) u_prio (
    .pend_i (pend_vec),
    .vld_o  (nxt_vld),
    .id_o   (nxt_id)
  );

  srcfg_intc_sel u_sel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (nxt_vld),
    .id_i   (nxt_id),
    .sel_o  (sel_q)
  );

  always_comb begin
    rd_val = '0;
    if (hit_cfg)      rd_val = cfg_q[word_idx[ID_W-1:0]];
    else if (hit_sel) rd_val = DATA_W'(sel_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         rsp_q <= '0;
    else if (req_valid_i && !req_write_i) rsp_q <= rd_val;
  end

  assign rsp_rdata_o = rsp_q;
  assign irq_o       = sel_q.vld;
endmodule

// File: rtl/srcfg_intc_chk.sv
module srcfg_intc_chk
  import srcfg_intc_pkg::*;
#(
  parameter map_e        MAP    = MAP_A,
  parameter int unsigned ADDR_W = 12
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic               req_write_i,
  input logic [ADDR_W-1:0]  req_addr_i,
  input logic [DATA_W-1:0]  rsp_rdata_o,
  input logic [NUM_SRC-1:0] irq_src_i,
  input logic [NUM_SRC-1:0] en_vec,
  input sel_t               sel_q,
  input logic               irq_o
);
  logic [NUM_SRC-1:0] pend;
  logic               rd_sel;

  assign pend   = irq_src_i & en_vec;
  assign rd_sel = req_valid_i && !req_write_i &&
                  (req_addr_i == ADDR_W'(sel_offset(MAP)));

  assert_irq_follows_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == $past(|pend));

  assert_lowest_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_q.vld |-> ((($past(pend) >> sel_q.id) & NUM_SRC'(1)) == NUM_SRC'(1)) &&
                  (($past(pend) & ((NUM_SRC'(1) << sel_q.id) - NUM_SRC'(1))) == '0));

  assert_sel_rsvd_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_sel) |-> rsp_rdata_o[DATA_W-1:ID_W+1] == '0);

  assert_flag_matches_irq_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_sel) |-> rsp_rdata_o[ID_W] == $past(irq_o));
endmodule

bind srcfg_intc srcfg_intc_chk #(.MAP(MAP), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_write_i (req_write_i),
  .req_addr_i  (req_addr_i),
  .rsp_rdata_o (rsp_rdata_o),
  .irq_src_i   (irq_src_i),
  .en_vec      (en_vec),
  .sel_q       (sel_q),
  .irq_o       (irq_o)
);

// File: tb/test_srcfg_intc.sv
module test_srcfg_intc;
  import srcfg_intc_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, write = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [63:0] src = '0;
  logic [31:0] rsp_a, rsp_b;
  logic        irq_a, irq_b;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  srcfg_intc #(.MAP(MAP_A)) i_srcfg_intc (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_write_i(write),
    .req_addr_i(addr), .req_wdata_i(wdata), .rsp_rdata_o(rsp_a),
    .irq_src_i(src), .irq_o(irq_a));

  srcfg_intc #(.MAP(MAP_B)) i_srcfg_intc_b (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_write_i(write),
    .req_addr_i(addr), .req_wdata_i(wdata), .rsp_rdata_o(rsp_b),
    .irq_src_i(src), .irq_o(irq_b));

  // reference model of map A
  logic [31:0] m_cfg [64];
  logic        m_vld;
  logic [5:0]  m_id;
  logic [31:0] m_rsp;

  function automatic logic [31:0] m_read(logic [11:0] a);
    if (a[1:0] != 2'b00) return 32'h0;
    if (a < 12'h100)     return m_cfg[a[7:2]];
    if (a == 12'h10C)    return {25'h0, m_vld, m_id};
    return 32'h0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_cfg[i]) m_cfg[i] = '0;
      m_vld = 0; m_id = 0; m_rsp = 0;
    end else begin
      logic       nv;
      logic [5:0] ni;
      nv = 0; ni = 0;
      if (valid && !write) m_rsp = m_read(addr);
      for (int i = 0; i < 64; i++)
        if (!nv && src[i] && m_cfg[i][6:0] == 7'h51) begin nv = 1; ni = 6'(i); end
      if (valid && write && addr[1:0] == 2'b00 && addr < 12'h100) m_cfg[addr[7:2]] = wdata;
      m_vld = nv; m_id = ni;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R6 irq_o vs model", {31'h0, irq_a}, {31'h0, m_vld});
    chk("R9 rsp_rdata_o vs model", rsp_a, m_rsp);
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); valid = 1; write = 1; addr = a; wdata = d;
    @(negedge clk); valid = 0; write = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] qa, output logic [31:0] qb);
    @(negedge clk);
    @(negedge clk); valid = 1; write = 0; addr = a;
    @(negedge clk); valid = 0;
    qa = rsp_a; qb = rsp_b;
  endtask

  task automatic drive(logic [63:0] v);
    @(negedge clk); src = v;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] a, b;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 irq_o after reset", {31'h0, irq_a}, 32'h0);
    rd(12'h10C, a, b); chk("R1 selection after reset", a, 32'h0);
    rd(12'h0FC, a, b); chk("R1 cfg63 after reset", a, 32'h0);

    // R2 full word storage, R3 upper bits ignored
    wr(12'h00C, 32'hABCD_0051);
    rd(12'h00C, a, b); chk("R2 cfg3 readback", a, 32'hABCD_0051);
    drive(64'h8);
    rd(12'h10C, a, b); chk("R3/R4 single source 3", a, 32'h43);
    chk("R3 map B ignores code 0x51", b, 32'h0);

    // R5 lowest wins
    wr(12'h004, 32'h51); wr(12'h0FC, 32'h51);
    drive(64'h8000_0000_0000_000A);
    rd(12'h10C, a, b); chk("R5 lowest of 1,3,63", a, 32'h41);

    // R10 mask-service-unmask
    wr(12'h004, 32'h0);
    rd(12'h10C, a, b); chk("R10 masked 1 moves to 3", a, 32'h43);
    wr(12'h00C, 32'hABCD_0000);
    rd(12'h10C, a, b); chk("R10 masked 3 moves to 63", a, 32'h7F);
    rd(12'h00C, a, b); chk("R2 upper bits kept after RMW", a, 32'hABCD_0000);

    // R3 wrong codes on active source 0
    drive(64'h8000_0000_0000_0009);
    wr(12'h000, 32'h52);
    rd(12'h10C, a, b); chk("R3 code 0x52 not enabled", a, 32'h7F);
    wr(12'h000, 32'h20);
    rd(12'h10C, a, b); chk("R3 other map code not enabled on A", a, 32'h7F);

    // R4 map B selection offset and unmapped cross offsets
    rd(12'h104, a, b);
    chk("R4 map B selection at 0x104", b, 32'h40);
    chk("R4 0x104 unmapped on map A", a, 32'h0);
    rd(12'h10C, a, b); chk("R4 0x10C unmapped on map B", b, 32'h0);

    // R8 ignored writes and unmapped reads
    wr(12'h10C, 32'h12);
    rd(12'h10C, a, b); chk("R8 selection write ignored", a, 32'h7F);
    wr(12'h300, 32'h51); wr(12'h001, 32'h51);
    rd(12'h300, a, b); chk("R8 unmapped read zero", a, 32'h0);
    rd(12'h000, a, b); chk("R8 stray writes left cfg0", a, 32'h20);
    rd(12'h00D, a, b); chk("R8 misaligned read zero", a, 32'h0);

    // R10 unmask
    wr(12'h00C, 32'hABCD_0051);
    rd(12'h10C, a, b); chk("R10 unmask restores 3", a, 32'h43);
    chk("R7 pending flag equals irq_o", {31'h0, a[6]}, {31'h0, irq_a});

    // R9 hold
    repeat (3) @(negedge clk);
    chk("R9 rsp holds without read", rsp_a, 32'h43);

    // R6 level release
    drive(64'h0);
    @(negedge clk);
    chk("R6 irq_o drops one cycle after release", {31'h0, irq_a}, 32'h0);
    rd(12'h10C, a, b); chk("R6 selection clear", a, 32'h0);
    chk("R7 map B flag equals irq", {31'h0, irq_b}, 32'h0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule